// File: doc/BRIEF.md
# Repeating Code Detector with Error-Tolerant Integration

This block watches a serial receive bit stream, one bit per strobe, for a programmable repeating pattern of 1 to 8 bits or 16 bits. It raises a status flag once the pattern has been present for a full integration window. It works at any pattern phase. It tolerates bit errors up to roughly one in a hundred. It accepts both framed and unframed streams, because the periodic framing bit, whether it is inserted or overwrites the pattern, costs only a few mismatches per window and the error budget absorbs them. A receive framer typically uses three instances of this block: one for the loop-up code, one for the loop-down code and one spare.

Each strobed bit is compared with the bit that arrived one pattern length earlier. A 16-bit history register holds those earlier bits. The mismatches in each window are counted. The flag is set at the end of a window only if two conditions hold: the count stayed within a budget, and the history lined up exactly with the programmed code at least once in that window. The second condition stops a constant stream of ones or zeros from being accepted as a code it is not. A host write to the first code byte restarts the integration.

Top module: `repeat_code_detector`

## Requirements
- R1: After reset, `code_present` is 0 and the integration window starts empty.
- R2: The length field `len_sel` selects a length of N bits for values 1 to 8 and 16 bits for every other value. A code of 1 to 7 bits is the top N bits of `code_a`, first-sent bit at bit 7, and `code_b` is not used. An 8-bit code is held in both bytes with the same value. A 16-bit code is `code_a` followed by `code_b`, each sent from its bit 7 first.
- R3: `code_present` is set only in the cycle after the strobe that completes a window of `WINDOW_BITS` strobed bits, counted from reset or from the last restart. It is not set before that strobe.
- R4: Detection does not depend on where the pattern starts relative to the window.
- R5: A window whose mismatch count stays at or below `ERR_LIMIT` is accepted. With one flipped bit per 100, the flag is still set.
- R6: A window whose mismatch count goes above `ERR_LIMIT` is rejected, and the flag is cleared at its end.
- R7: A window is rejected if the most recent N bits never equal the programmed code during it, even when the stream is perfectly periodic (for example, all ones against code `80h` with a length of 5).
- R8: Once set, the flag holds through the following window and changes only at the end of a window or on a restart. It clears at the end of a window that fails.
- R9: A pulse on `code_a_wr` clears the flag and restarts the window. A new decision follows exactly `WINDOW_BITS` strobes later.
- R10: Clock cycles with `bit_en` low do not affect the history, the window count or the flag.
- R11: The mismatch tally saturates just above `ERR_LIMIT`. A count of any size therefore fails the window and never wraps into an accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Strobe marking a valid received bit |
| rx_bit | input | 1 | Received serial bit |
| len_sel | input | 4 | Pattern length select (1 to 8, else 16) |
| code_a | input | 8 | First code byte |
| code_b | input | 8 | Second code byte |
| code_a_wr | input | 1 | Pulse: first code byte written, restarts integration |
| code_present | output | 1 | Sticky flag: code present |

## Verification
The bench builds the detector with `WINDOW_BITS` = 1000, which leaves `ERR_LIMIT` at its derived value of 51. A window therefore lasts about a thousand cycles, so acceptance, rejection and sticky clearing across two windows all fit in a short run. At that size, one flip per 100 bits stays well inside the budget and one flip per 20 bits exceeds it by a wide margin. A 6-bit tally would also wrap past 63 without saturation, so the heavy-error case shows whether the tally saturates.

// File: rtl/codedet_pkg.sv
package codedet_pkg;

    localparam int HIST_W = 16;

    typedef logic [4:0] pat_len_t;

    // Length select: 1..8 literal, anything else means 16 bits.
    function automatic pat_len_t decode_len(input logic [3:0] sel);
        if (sel >= 4'd1 && sel <= 4'd8) begin
            return pat_len_t'(sel);
        end
        return 5'd16;
    endfunction

    // Lengths of 8 and 16 compare a full 16-bit history; shorter ones only N bits.
    function automatic logic [HIST_W-1:0] ref_mask(input pat_len_t len);
        logic [HIST_W-1:0] m;
        m = '0;
        for (int i = 0; i < HIST_W; i++) begin
            m[i] = (len >= 5'd8) || (5'(i) < len);
        end
        return m;
    endfunction

    // Reference image of the history when the code sits in phase.
    function automatic logic [HIST_W-1:0] ref_image(input pat_len_t len,
                                                    input logic [7:0] a,
                                                    input logic [7:0] b);
        logic [HIST_W-1:0] w;
        if (len >= 5'd8) begin
            w = {a, b};
        end else begin
            w = {8'h00, a} >> (5'd8 - len);
        end
        return w;
    endfunction

endpackage

// File: rtl/codedet_history.sv
module codedet_history
    import codedet_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  pat_len_t          len,
    input  logic [HIST_W-1:0] ref_pat,
    input  logic [HIST_W-1:0] ref_msk,
    output logic              mism,
    output logic              aligned
);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } hist_state_t;

    hist_state_t st_d, st_q;
    logic [3:0]  lag_idx;
    logic        lag_bit;

    always_comb begin
        st_d    = st_q;
        lag_idx = 4'(len - 5'd1);
        lag_bit = st_q.hist[lag_idx];
        mism    = bit_en && (rx_bit != lag_bit);
        if (bit_en) begin
            st_d.hist = {st_q.hist[HIST_W-2:0], rx_bit};
        end
        aligned = bit_en && ((st_d.hist & ref_msk) == (ref_pat & ref_msk));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(st_q.hist)); // R10

endmodule

// File: rtl/codedet_integrator.sv
module codedet_integrator #(
    parameter int WINDOW_BITS = 46320,
    parameter int ERR_LIMIT   = 1645
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic restart,
    input  logic mism,
    input  logic aligned,
    output logic present
);

    localparam int CNT_W = (WINDOW_BITS > 2) ? $clog2(WINDOW_BITS) : 1;
    localparam int ERR_W = $clog2(ERR_LIMIT + 2);
    localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(WINDOW_BITS - 1);
    localparam logic [ERR_W-1:0] ERR_SAT  = ERR_W'(ERR_LIMIT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] win_cnt;
        logic [ERR_W-1:0] err_cnt;
        logic             seen;
        logic             present;
    } integ_state_t;

    integ_state_t     st_d, st_q;
    logic [ERR_W-1:0] err_next;
    logic             seen_next;
    logic             win_end;

    always_comb begin
        st_d      = st_q;
        err_next  = st_q.err_cnt;
        if (mism && (st_q.err_cnt != ERR_SAT)) begin
            err_next = st_q.err_cnt + 1'b1;
        end
        seen_next = st_q.seen | aligned;
        win_end   = bit_en && (st_q.win_cnt == WIN_LAST);

        if (restart) begin
            st_d = '0;
        end else if (bit_en) begin
            if (win_end) begin
                st_d.present = (err_next != ERR_SAT) && seen_next;
                st_d.win_cnt = '0;
                st_d.err_cnt = '0;
                st_d.seen    = 1'b0;
            end else begin
                st_d.win_cnt = st_q.win_cnt + 1'b1;
                st_d.err_cnt = err_next;
                st_d.seen    = seen_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign present = st_q.present;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err_cnt <= ERR_SAT); // R11

    AST_SET_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.present) |-> $past(win_end && !restart)); // R3

    AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.present) |-> $past(restart || win_end)); // R8

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!st_q.present && st_q.win_cnt == '0)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !restart) |=> ($stable(st_q.win_cnt) && $stable(st_q.present))); // R10

endmodule

// File: rtl/repeat_code_detector.sv
module repeat_code_detector
    import codedet_pkg::*;
#(
    parameter int WINDOW_BITS = 46320,
    parameter int ERR_LIMIT   = (WINDOW_BITS * 3) / 100 + WINDOW_BITS / 193 + HIST_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       rx_bit,
    input  logic [3:0] len_sel,
    input  logic [7:0] code_a,
    input  logic [7:0] code_b,
    input  logic       code_a_wr,
    output logic       code_present
);

    pat_len_t          len;
    logic [HIST_W-1:0] ref_pat;
    logic [HIST_W-1:0] ref_msk;
    logic              mism;
    logic              aligned;

    always_comb begin
        len     = decode_len(len_sel);
        ref_pat = ref_image(len, code_a, code_b);
        ref_msk = ref_mask(len);
    end

    codedet_history u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .rx_bit  (rx_bit),
        .len     (len),
        .ref_pat (ref_pat),
        .ref_msk (ref_msk),
        .mism    (mism),
        .aligned (aligned)
    );

    codedet_integrator #(
        .WINDOW_BITS (WINDOW_BITS),
        .ERR_LIMIT   (ERR_LIMIT)
    ) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .restart (code_a_wr),
        .mism    (mism),
        .aligned (aligned),
        .present (code_present)
    );

endmodule

// File: tb/repeat_code_detector_test.sv
`timescale 1ns/1ps
module repeat_code_detector_test;

    localparam int W = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b0;
    logic [3:0] len_sel = 4'd5;
    logic [7:0] code_a = 8'h80;
    logic [7:0] code_b = 8'h00;
    logic       code_a_wr = 1'b0;
    logic       code_present;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    repeat_code_detector #(.WINDOW_BITS(W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .rx_bit       (rx_bit),
        .len_sel      (len_sel),
        .code_a       (code_a),
        .code_b       (code_b),
        .code_a_wr    (code_a_wr),
        .code_present (code_present)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: code_present=%0b expected %0b", req, act, exp);
        end
    endtask

    function automatic logic pat_bit(input int len, input logic [7:0] a,
                                     input logic [7:0] b, input int idx);
        int k;
        if (len < 16) begin
            k = idx % len;
            return a[7-k];
        end
        k = idx % 16;
        return (k < 8) ? a[7-k] : b[15-k];
    endfunction

    task automatic restart(input logic [3:0] sel, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        bit_en    = 1'b0;
        len_sel   = sel;
        code_a    = a;
        code_b    = b;
        code_a_wr = 1'b1;
        @(negedge clk);
        code_a_wr = 1'b0;
    endtask

    // Sends n strobed bits of the code (from phase), flipping one per err_per bits.
    // Ends on a negedge after the last bit has been taken, strobe low.
    task automatic send_code(input int len, input int phase, input int n, input int err_per);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_en = 1'b1;
            rx_bit = pat_bit(len, code_a, code_b, phase + i);
            if (err_per != 0 && (i % err_per) == err_per / 2) rx_bit = ~rx_bit;
        end
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_const(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_en = 1'b1;
            rx_bit = v;
        end
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_alt(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_en = 1'b1;
            rx_bit = i[0];
        end
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic t_reset();
        check(code_present, 1'b0, "R1 reset");
    endtask

    task automatic t_len5();
        restart(4'd5, 8'h80, 8'h5A);   // code_b unused at this length
        send_code(5, 0, W - 1, 0);
        check(code_present, 1'b0, "R3 no early set");
        send_code(5, W - 1, 1, 0);
        check(code_present, 1'b1, "R3 R2 set at window end, length 5");
    endtask

    task automatic t_len16_phase();
        restart(4'd0, 8'hC3, 8'h5A);
        send_code(16, 7, W, 0);
        check(code_present, 1'b1, "R4 R2 length 16 at phase 7");
    endtask

    task automatic t_len8();
        restart(4'd8, 8'h96, 8'h96);
        send_code(8, 3, W, 0);
        check(code_present, 1'b1, "R2 length 8");
    endtask

    task automatic t_len1();
        restart(4'd1, 8'h80, 8'h00);
        send_const(1'b1, W);
        check(code_present, 1'b1, "R2 length 1 all ones");
    endtask

    task automatic t_const_reject();
        restart(4'd5, 8'h80, 8'h00);
        send_const(1'b1, W);
        check(code_present, 1'b0, "R7 all ones vs 10000");
        restart(4'd1, 8'h00, 8'h00);
        send_const(1'b1, W);
        check(code_present, 1'b0, "R7 all ones vs 0");
    endtask

    task automatic t_errors();
        restart(4'd0, 8'hC3, 8'h5A);
        send_code(16, 0, W, 100);
        check(code_present, 1'b1, "R5 one flip per 100");
        restart(4'd0, 8'hC3, 8'h5A);
        send_code(16, 0, W, 20);
        check(code_present, 1'b0, "R6 R11 one flip per 20");
        send_code(16, 0, W, 0);
        check(code_present, 1'b1, "R11 clean window after heavy errors");
    endtask

    task automatic t_sticky();
        restart(4'd3, 8'hC0, 8'h00);
        send_code(3, 0, W, 0);
        check(code_present, 1'b1, "R8 set");
        send_alt(W / 2);
        check(code_present, 1'b1, "R8 held mid-window");
        send_alt(W / 2 - 1);
        check(code_present, 1'b1, "R8 held before window end");
        send_alt(1);
        check(code_present, 1'b0, "R8 R6 cleared after failing window");
    endtask

    task automatic t_write_restart();
        restart(4'd5, 8'h80, 8'h00);
        send_code(5, 0, W, 0);
        check(code_present, 1'b1, "R9 set before write");
        send_code(5, W, 300, 0);
        restart(4'd5, 8'h80, 8'h00);
        check(code_present, 1'b0, "R9 write clears flag");
        send_code(5, 0, W - 1, 0);
        check(code_present, 1'b0, "R9 new window not done");
        send_code(5, W - 1, 1, 0);
        check(code_present, 1'b1, "R9 set after full new window");
    endtask

    task automatic t_gated();
        restart(4'd0, 8'hE1, 8'h3C);
        for (int i = 0; i < W - 1; i++) begin
            @(negedge clk);
            bit_en = 1'b1;
            rx_bit = pat_bit(16, code_a, code_b, i);
            @(negedge clk);
            bit_en = 1'b0;
            rx_bit = ~pat_bit(16, code_a, code_b, i);
        end
        repeat (20) @(negedge clk);
        check(code_present, 1'b0, "R10 idle cycles not counted");
        send_code(16, W - 1, 1, 0);
        check(code_present, 1'b1, "R10 set after last strobed bit");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_len5();
        t_len16_phase();
        t_len8();
        t_len1();
        t_const_reject();
        t_errors();
        t_sticky();
        t_write_restart();
        t_gated();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule